// File: doc/BRIEF.md
# Overwriting Circular Block Buffer

This block is a 24-slot ring buffer that sits between an internal block producer and a host. The producer pushes one entry per write strobe. Each entry is a 16-bit data word with a 2-bit block identifier. The host pulls entries one at a time with a read strobe and gets them back in arrival order. The block tracks a write pointer, a read pointer and an occupancy count from 0 to 24. It reports three conditions: a latched "something arrived" flag, a full level and a sticky overflow flag. The first two also act as interrupt lines.

When the producer writes while 24 unread entries are held, the new entry replaces the oldest one. The read pointer then moves forward together with the write pointer, so the host always drains the newest 24 entries. The overflow flag stays set until the host has popped 24 entries in a row with no further overwrite in between.

A control write with the address-reset bit set returns both pointers to slot 0 and empties the buffer. It clears every flag and raises a resynchronisation request for one cycle.

Top module: `ovw_block_ring`

## Requirements
- R1: Entries are returned in the order they were written. Each entry carries its 16-bit data and its 2-bit identifier unchanged. The buffer never holds more than 24 unread entries.
- R2: A read strobe while the buffer is empty pops nothing and leaves the read pointer where it is. The next entry written is the one the following read returns.
- R3: `irq_nempty` becomes 1 on the edge after any accepted write. It becomes 0 on the edge after a status read (`stat_rd_stb`) that has no accepted write in the same cycle. A write and a status read in the same cycle leave it at 1.
- R4: `irq_full` is 1 exactly while 24 unread entries are held. It updates on the edge that changes the count.
- R5: A write without a read while 24 entries are held sets `flag_ovf` on that edge. It overwrites the oldest entry, so the following reads return the 24 newest entries in order.
- R6: `flag_ovf` clears on the edge of the 24th entry popped since the most recent overwrite. It does not clear before that, and a new overwrite restarts the count.
- R7: A read and a write in the same cycle while the buffer is not empty move both pointers and keep the count. This also holds when the buffer is full: no overflow and `irq_full` stays 1.
- R8: When `ctl_wr_stb` and `ctl_ares` are both 1, the next edge empties the buffer with both pointers at slot 0. It clears `irq_nempty`, `irq_full` and `flag_ovf`, drops a write in the same cycle, and sets `resync_req` for exactly one cycle.
- R9: While `rst` is 1 on an edge, all flags, `resync_req` and the read data outputs become 0.
- R10: A read strobe loads `rd_data`/`rd_id` on its edge. The outputs then hold their value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Producer write strobe, one entry per cycle |
| wr_data | input | 16 | Data word to store |
| wr_id | input | 2 | Block identifier to store |
| rd_stb | input | 1 | Host read strobe, pops one entry if any |
| rd_data | output | 16 | Data word of the last read |
| rd_id | output | 2 | Identifier of the last read |
| stat_rd_stb | input | 1 | Host read of the status register |
| ctl_wr_stb | input | 1 | Host write of the control register |
| ctl_ares | input | 1 | Address-reset bit of the control write |
| irq_nempty | output | 1 | Latched not-empty interrupt |
| irq_full | output | 1 | Full interrupt level |
| flag_ovf | output | 1 | Sticky overflow flag |
| resync_req | output | 1 | One-cycle resynchronisation request |

## Verification
The hardest state to reach from the ports is the release of the overflow flag. It needs a full buffer, at least one overwrite, and then exactly 24 pops with no overwrite among them. A second overwrite partway through must restart the count. Directed sequences fill the buffer, overwrite, and check the flag after 23 and after 24 reads. Random phases then bias the write rate well above the read rate, so overwrites land in the middle of drain runs. A cycle-level reference model in the bench predicts every flag and every read word.

// File: rtl/ovw_ring_pkg.sv
package ovw_ring_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_BOTH,
    OP_OVERWRITE,
    OP_CLEAR
  } ring_op_e;

  function automatic logic op_stores(ring_op_e op);
    return (op == OP_PUSH) || (op == OP_BOTH) || (op == OP_OVERWRITE);
  endfunction

  function automatic logic op_pops(ring_op_e op);
    return (op == OP_POP) || (op == OP_BOTH);
  endfunction

endpackage

// File: rtl/ovw_ring_mem.sv
module ovw_ring_mem #(
  parameter int DEPTH = 24,
  parameter int WIDTH = 18,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      ram[waddr] <= wdata;
    end
  end

  // read-first output register with its own synchronous reset
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= ram[raddr];
    end
  end

endmodule

// File: rtl/ovw_ring_decode.sv
module ovw_ring_decode
  import ovw_ring_pkg::*;
#(
  parameter int DEPTH = 24,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          clear,
  input  logic [CW-1:0] occ,
  output ring_op_e      op
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic has_data;
  logic is_full;

  assign has_data = (occ != '0);
  assign is_full  = (occ == FULL_CNT);

  always_comb begin
    if (clear) begin
      op = OP_CLEAR;
    end else if (wr_stb && rd_stb && has_data) begin
      op = OP_BOTH;
    end else if (wr_stb && is_full) begin
      op = OP_OVERWRITE;
    end else if (wr_stb) begin
      op = OP_PUSH;
    end else if (rd_stb && has_data) begin
      op = OP_POP;
    end else begin
      op = OP_IDLE;
    end
  end

endmodule

// File: rtl/ovw_ring_ctrl.sv
module ovw_ring_ctrl
  import ovw_ring_pkg::*;
#(
  parameter int DEPTH = 24,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  ring_op_e      op,
  input  logic          stat_rd_stb,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] occ,
  output logic          irq_nempty,
  output logic          irq_full,
  output logic          flag_ovf,
  output logic          resync_req
);

  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

  logic [CW-1:0] occ_nxt;
  logic [AW-1:0] drain_cnt;
  logic          adv_wr;
  logic          adv_rd;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + AW'(1);
  endfunction

  assign adv_wr = op_stores(op);
  assign adv_rd = op_pops(op) || (op == OP_OVERWRITE);

  always_comb begin
    case (op)
      OP_PUSH:  occ_nxt = occ + CW'(1);
      OP_POP:   occ_nxt = occ - CW'(1);
      OP_CLEAR: occ_nxt = '0;
      default:  occ_nxt = occ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || op == OP_CLEAR) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (adv_wr) wr_ptr <= bump(wr_ptr);
      if (adv_rd) rd_ptr <= bump(rd_ptr);
      occ <= occ_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_nempty <= 1'b0;
      irq_full   <= 1'b0;
      resync_req <= 1'b0;
    end else begin
      resync_req <= (op == OP_CLEAR);
      irq_full   <= (occ_nxt == FULL_CNT);
      if (op == OP_CLEAR) begin
        irq_nempty <= 1'b0;
      end else if (adv_wr) begin
        irq_nempty <= 1'b1;
      end else if (stat_rd_stb) begin
        irq_nempty <= 1'b0;
      end
    end
  end

  // overflow release: count pops since the latest overwrite
  always_ff @(posedge clk) begin
    if (rst || op == OP_CLEAR) begin
      flag_ovf  <= 1'b0;
      drain_cnt <= '0;
    end else if (op == OP_OVERWRITE) begin
      flag_ovf  <= 1'b1;
      drain_cnt <= '0;
    end else if (flag_ovf && op_pops(op)) begin
      if (drain_cnt == LAST_SLOT) begin
        flag_ovf  <= 1'b0;
        drain_cnt <= '0;
      end else begin
        drain_cnt <= drain_cnt + AW'(1);
      end
    end
  end

endmodule

// File: rtl/ovw_block_ring.sv
module ovw_block_ring
  import ovw_ring_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int DATA_W = 16,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ID_W-1:0]   wr_id,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic [ID_W-1:0]   rd_id,
  input  logic              stat_rd_stb,
  input  logic              ctl_wr_stb,
  input  logic              ctl_ares,
  output logic              irq_nempty,
  output logic              irq_full,
  output logic              flag_ovf,
  output logic              resync_req
);

  localparam int ENT_W = DATA_W + ID_W;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  ring_op_e      op;
  logic          clear;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] occ;
  logic [ENT_W-1:0] rd_word;

  assign clear = ctl_wr_stb && ctl_ares;

  ovw_ring_decode #(.DEPTH(DEPTH)) u_decode (
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .clear  (clear),
    .occ    (occ),
    .op     (op)
  );

  ovw_ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .op          (op),
    .stat_rd_stb (stat_rd_stb),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .occ         (occ),
    .irq_nempty  (irq_nempty),
    .irq_full    (irq_full),
    .flag_ovf    (flag_ovf),
    .resync_req  (resync_req)
  );

  ovw_ring_mem #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (op_stores(op)),
    .waddr (wr_ptr),
    .wdata ({wr_id, wr_data}),
    .re    (rd_stb),
    .raddr (rd_ptr),
    .rdata (rd_word)
  );

  assign rd_data = rd_word[DATA_W-1:0];
  assign rd_id   = rd_word[ENT_W-1:DATA_W];

endmodule

// File: rtl/ovw_block_ring_chk.sv
module ovw_block_ring_chk #(
  parameter int DEPTH  = 24,
  parameter int DATA_W = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic              ctl_wr_stb,
  input logic              ctl_ares,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_nempty,
  input logic              irq_full,
  input logic              flag_ovf,
  input logic              resync_req,
  input logic [CW-1:0]     occ
);

  logic clr;
  logic seen_rd;
  assign clr = ctl_wr_stb && ctl_ares;

  always_ff @(posedge clk) begin
    if (rst) seen_rd <= 1'b0;
    else if (rd_stb) seen_rd <= 1'b1;
  end

  p_occ_bound_r1: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  p_empty_read_r2: assert property (@(posedge clk) disable iff (rst)
    (occ == '0 && rd_stb && !wr_stb && !clr) |=> (occ == '0));

  p_nempty_set_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !clr) |=> irq_nempty);

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !rd_stb && irq_full && !clr) |=> (flag_ovf && irq_full));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_ovf && !rd_stb && !clr) |=> flag_ovf);

  p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_full && wr_stb && rd_stb && !clr) |=> irq_full);

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (resync_req && !irq_nempty && !irq_full && !flag_ovf));

  p_resync_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> !resync_req);

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (seen_rd && !rd_stb) |=> $stable(rd_data));

endmodule

bind ovw_block_ring ovw_block_ring_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_stb     (wr_stb),
  .rd_stb     (rd_stb),
  .ctl_wr_stb (ctl_wr_stb),
  .ctl_ares   (ctl_ares),
  .rd_data    (rd_data),
  .irq_nempty (irq_nempty),
  .irq_full   (irq_full),
  .flag_ovf   (flag_ovf),
  .resync_req (resync_req),
  .occ        (occ)
);

// File: tb/ovw_block_ring_bench.sv
module ovw_block_ring_bench;

  localparam int CLK_P = 10;
  localparam int DEPTH = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_id = '0;
  logic        rd_stb = 1'b0;
  logic [15:0] rd_data;
  logic [1:0]  rd_id;
  logic        stat_rd_stb = 1'b0;
  logic        ctl_wr_stb = 1'b0;
  logic        ctl_ares = 1'b0;
  logic        irq_nempty, irq_full, flag_ovf, resync_req;

  always #(CLK_P/2) clk = ~clk;

  ovw_block_ring u_ovw_block_ring (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .wr_id(wr_id),
    .rd_stb(rd_stb), .rd_data(rd_data), .rd_id(rd_id), .stat_rd_stb(stat_rd_stb),
    .ctl_wr_stb(ctl_wr_stb), .ctl_ares(ctl_ares), .irq_nempty(irq_nempty),
    .irq_full(irq_full), .flag_ovf(flag_ovf), .resync_req(resync_req)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // reference model state
  logic [17:0] m_mem [DEPTH];
  bit          m_val [DEPTH];
  int m_wp, m_rp, m_occ, m_drain;
  bit m_nempty, m_full, m_ovf, m_resync;
  logic [17:0] m_rd;
  bit m_rd_ok;
  string rd_req = "R10";

  function automatic int nxt(int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_val[i] = 1'b0;
    m_wp = 0; m_rp = 0; m_occ = 0; m_drain = 0;
    m_nempty = 0; m_full = 0; m_ovf = 0; m_resync = 0;
    m_rd = '0; m_rd_ok = 1'b1;
  endtask

  task automatic model_step(bit w, logic [17:0] d, bit r, bit st, bit ar);
    bit pop;
    if (r) begin
      m_rd = m_mem[m_rp];
      m_rd_ok = m_val[m_rp];
    end
    m_resync = ar;
    if (ar) begin
      m_wp = 0; m_rp = 0; m_occ = 0; m_drain = 0;
      m_nempty = 0; m_full = 0; m_ovf = 0;
      return;
    end
    pop = r && (m_occ != 0);
    if (w) begin
      m_mem[m_wp] = d;
      m_val[m_wp] = 1'b1;
      m_nempty = 1;
    end else if (st) begin
      m_nempty = 0;
    end
    if (w && !pop && m_occ == DEPTH) begin
      m_wp = nxt(m_wp); m_rp = nxt(m_rp);
      m_ovf = 1; m_drain = 0;
    end else begin
      if (w) begin m_wp = nxt(m_wp); m_occ++; end
      if (pop) begin
        m_rp = nxt(m_rp); m_occ--;
        if (m_ovf) begin
          if (m_drain == DEPTH - 1) begin m_ovf = 0; m_drain = 0; end
          else m_drain++;
        end
      end
    end
    m_full = (m_occ == DEPTH);
  endtask

  task automatic compare_all();
    check("R3", "irq_nempty", int'(irq_nempty), int'(m_nempty));
    check("R4", "irq_full", int'(irq_full), int'(m_full));
    check("R5", "flag_ovf", int'(flag_ovf), int'(m_ovf));
    check("R8", "resync_req", int'(resync_req), int'(m_resync));
    if (m_rd_ok) check(rd_req, "rd_word", int'({rd_id, rd_data}), int'(m_rd));
  endtask

  // one clock: drive at the falling edge, check at the next falling edge
  task automatic tick(bit w, logic [17:0] d, bit r, bit st, bit ar);
    wr_stb = w; wr_id = d[17:16]; wr_data = d[15:0];
    rd_stb = r; stat_rd_stb = st; ctl_wr_stb = ar; ctl_ares = ar;
    model_step(w, d, r, st, ar);
    @(posedge clk);
    @(negedge clk);
    wr_stb = 0; rd_stb = 0; stat_rd_stb = 0; ctl_wr_stb = 0; ctl_ares = 0;
    compare_all();
  endtask

  function automatic logic [17:0] pat(int k);
    return 18'((k * 16'h9e37 + 16'h1234) ^ (k << 16));
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R9: reset state
    check("R9", "irq_nempty", int'(irq_nempty), 0);
    check("R9", "irq_full", int'(irq_full), 0);
    check("R9", "flag_ovf", int'(flag_ovf), 0);
    check("R9", "resync_req", int'(resync_req), 0);
    check("R9", "rd_word", int'({rd_id, rd_data}), 0);

    // R1: order and content
    rd_req = "R1";
    for (int k = 0; k < 3; k++) tick(1, pat(k), 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      tick(0, '0, 1, 0, 0);
      check("R1", "read order", int'({rd_id, rd_data}), int'(pat(k)));
    end
    check("R3", "nempty held until status read", int'(irq_nempty), 1);
    tick(0, '0, 0, 1, 0);
    check("R3", "nempty after status read", int'(irq_nempty), 0);

    // R2: empty reads do not move the pointer
    rd_req = "R2";
    tick(0, '0, 1, 0, 0);
    tick(0, '0, 1, 0, 0);
    tick(1, pat(40), 0, 0, 0);
    tick(0, '0, 1, 0, 0);
    check("R2", "read after empty reads", int'({rd_id, rd_data}), int'(pat(40)));
    check("R4", "not full", int'(irq_full), 0);

    // R3: write and status read together keep the flag
    tick(1, pat(41), 0, 1, 0);
    check("R3", "write beats status read", int'(irq_nempty), 1);
    tick(0, '0, 1, 0, 0);

    // R4/R5/R6: fill, overwrite, drain
    rd_req = "R5";
    for (int k = 0; k < DEPTH - 1; k++) tick(1, pat(100 + k), 0, 0, 0);
    check("R4", "not full at 23", int'(irq_full), 0);
    tick(1, pat(123), 0, 0, 0);
    check("R4", "full at 24", int'(irq_full), 1);
    check("R5", "no overflow at 24", int'(flag_ovf), 0);
    // R7: read and write together at full
    tick(1, pat(124), 1, 0, 0);
    check("R7", "full held on read+write", int'(irq_full), 1);
    check("R7", "no overflow on read+write", int'(flag_ovf), 0);
    tick(1, pat(125), 0, 0, 0);
    check("R5", "overflow set", int'(flag_ovf), 1);
    tick(1, pat(126), 0, 0, 0);
    for (int k = 0; k < DEPTH - 1; k++) begin
      tick(0, '0, 1, 0, 0);
      check("R5", "newest entries", int'({rd_id, rd_data}), int'(pat(103 + k)));
    end
    check("R6", "overflow kept after 23 reads", int'(flag_ovf), 1);
    tick(0, '0, 1, 0, 0);
    check("R6", "overflow cleared after 24 reads", int'(flag_ovf), 0);

    // R6: an overwrite mid-drain restarts the count
    for (int k = 0; k < DEPTH + 1; k++) tick(1, pat(200 + k), 0, 0, 0);
    for (int k = 0; k < 10; k++) tick(0, '0, 1, 0, 0);
    for (int k = 0; k < 11; k++) tick(1, pat(300 + k), 0, 0, 0);
    for (int k = 0; k < DEPTH - 1; k++) tick(0, '0, 1, 0, 0);
    check("R6", "restarted count not done", int'(flag_ovf), 1);
    tick(0, '0, 1, 0, 0);
    check("R6", "restarted count done", int'(flag_ovf), 0);

    // R8: address reset with a same-cycle write
    for (int k = 0; k < 5; k++) tick(1, pat(400 + k), 0, 0, 0);
    tick(1, pat(499), 0, 0, 1);
    check("R8", "resync pulse", int'(resync_req), 1);
    check("R8", "nempty cleared", int'(irq_nempty), 0);
    tick(0, '0, 0, 0, 0);
    check("R8", "resync one cycle", int'(resync_req), 0);
    rd_req = "R8";
    tick(1, pat(500), 0, 0, 0);
    tick(0, '0, 1, 0, 0);
    check("R8", "first entry after reset", int'({rd_id, rd_data}), int'(pat(500)));

    // random phases, write-heavy and read-heavy in turn
    rd_req = "R10";
    for (int ph = 0; ph < 12; ph++) begin
      int wp_pct = (ph % 2 == 0) ? 85 : 30;
      int rp_pct = (ph % 2 == 0) ? 30 : 80;
      for (int c = 0; c < 400; c++) begin
        bit w  = ($urandom % 100) < wp_pct;
        bit r  = ($urandom % 100) < rp_pct;
        bit st = ($urandom % 100) < 8;
        bit ar = ($urandom % 1000) < 3;
        tick(w, 18'($urandom), r, st, ar);
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule